// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a small set of register writes into a complete NAND flash bus transaction. Software loads the address bytes, the data byte count and an optional follow-up opcode, then writes a command word whose top bit starts the run. The sequencer issues the first opcode with the command latch raised and the address bytes with the address latch raised. It then moves the data bytes through a byte-wide buffer port and issues the follow-up opcode. When the device goes busy, the sequencer waits for the ready/busy line before it finishes.

A single command word carries the opcode, the data direction, the number of address cycles and the chip-enable choice. Where the follow-up opcode goes depends on the direction. A read puts it right after the address bytes, so it acts as a read start and the data comes out once the device is ready again. A write, or a command with no data, puts it after the data phase, so it acts as a program or erase confirm. Completion is reported by sticky write-one-to-clear status bits: one for command done and one for data transfer done.

Every bus cycle drives its strobe low for `STROBE_CYC` clocks and then high for `STROBE_CYC` clocks. Timing beyond this fixed strobe width, bus-master transfers and ECC are outside the block.

Top module: `nand_seq`

## Requirements
- R1: While reset is asserted and after it, both chip enables are high (inactive), both strobes are high, the command and address latches are low, the data pins are not driven and the status word is zero.
- R2: Writing register index 0 with bit 31 set starts a command when the sequencer is idle. The first bus cycle carries bits 7:0 with the command latch high. The write strobe is low for `STROBE_CYC` clocks, then high for `STROBE_CYC` clocks. Chip enable 1 is low for the whole command when bit 19 is set, and chip enable 0 is low when bit 19 is clear.
- R3: Bit 30 of the command word enables the address phase, and bits 29:27 hold the cycle count minus one. Address bytes go out lowest byte first from the vector {index 3 bits 23:0, index 2 bits 15:0}, with the address latch high.
- R4: Register index 1 holds a follow-up opcode in bits 7:0 and a valid flag in bit 8. When command bit 26 (read) is set, the follow-up goes out right after the address phase. Otherwise it goes out after the data phase, or after the address phase when there is no data.
- R5: After the follow-up opcode the sequencer waits `TWB_CYC` clocks, then issues no strobe until the ready/busy input is high.
- R6: With bit 26 set and a nonzero length (register index 4), exactly that many bytes are read with the read strobe. Each byte is sampled on the strobe's rising edge and written to buffer index 0, 1, 2 and so on. The data pins are never driven while the read strobe is low.
- R7: With bit 25 set and bit 26 clear, exactly the length's count of bytes is written with the write strobe. Each byte is taken from the buffer read port at the index shown, with both latches low.
- R8: The status word (register index 5) sets bit 31 when a command finishes and bit 28 after the last data byte. Writing a one to a bit clears it, except that a set in the same clock wins.
- R9: A command word written while a command is running is ignored and sets sticky status bit 0. Bit 0 clears only by writing a one to it. Configuration registers are likewise frozen while a command runs.
- R10: The command and address latches are never high together, the read and write strobes are never low together, and at most one chip enable is low.
- R11: When the length is zero, or when neither bit 25 nor bit 26 is set, there is no data phase and status bit 28 stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regIdx | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| irqStatus | output | 32 | Status: bit 31 done, bit 28 transfer done, bit 0 busy-write error |
| ceN | output | 2 | Chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Flash data bus output |
| ioOe | output | 1 | Flash data bus output enable |
| ioIn | input | 8 | Flash data bus input |
| rb | input | 1 | Ready/busy from flash, high when ready |
| bufWrEn | output | 1 | Buffer write enable for read data |
| bufWrIdx | output | LEN_W | Buffer write index |
| bufWrData | output | 8 | Buffer write data |
| bufRdIdx | output | LEN_W | Buffer read index for write data |
| bufRdData | input | 8 | Buffer read data |

## Verification
Two things can land in the same clock: the sequencer setting the done bit in its final cycle, and software writing a one to clear that bit. The bench provokes this with a command that has only an opcode. It counts the clocks from the start write to the finishing cycle and presents the clear exactly there, then expects the done bit to remain set. A second clear one cycle later must then empty it. The same finishing window is also where a command word written too early must be rejected, and the bench judges that rejection from the bus log and the sticky error bit.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int REG_CMD     = 0;
  localparam int REG_FOLLOW  = 1;
  localparam int REG_ADDR_LO = 2;
  localparam int REG_ADDR_HI = 3;
  localparam int REG_LEN     = 4;
  localparam int REG_IRQ     = 5;

  localparam int CMD_GO     = 31;
  localparam int CMD_ADR_EN = 30;
  localparam int CMD_RD     = 26;
  localparam int CMD_WR     = 25;
  localparam int CMD_CS     = 19;
  localparam int FOLLOW_VAL = 8;

  localparam int IRQ_DONE = 31;
  localparam int IRQ_XFER = 28;
  localparam int IRQ_ERR  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC1, ST_ADDR, ST_OPC2, ST_WB, ST_BUSY, ST_DATA, ST_FIN
  } seqState_e;

  typedef enum logic [1:0] {IO_OPC1, IO_ADDR, IO_OPC2, IO_DATA} ioSel_e;

  typedef struct packed {
    logic   ceOn;
    ioSel_e ioSel;
    logic   capture;
    logic   idxAdv;
    logic   idxClr;
    logic   setXfer;
    logic   setDone;
  } seqCtl_t;

  typedef struct packed {
    logic       rd;
    logic       addrEn;
    logic [2:0] addrM1;
    logic       followEn;
    logic       hasData;
    logic       lastAddr;
    logic       lastByte;
  } seqInfo_t;

endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int MAX_ADDR_CYC = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regIdx,
  input  logic [31:0]      regWdata,
  input  logic             busy,
  input  seqCtl_t          ctl,
  input  logic [7:0]       ioIn,
  input  logic [7:0]       bufRdData,
  output logic             go,
  output seqInfo_t         info,
  output logic [31:0]      irqStatus,
  output logic [1:0]       ceN,
  output logic [7:0]       ioOut,
  output logic             bufWrEn,
  output logic [LEN_W-1:0] bufWrIdx,
  output logic [7:0]       bufWrData,
  output logic [LEN_W-1:0] bufRdIdx
);
  localparam int ADDR_BITS = 8 * MAX_ADDR_CYC;
  localparam int HI_BITS   = ADDR_BITS - 16;

  logic [7:0]           opcode;
  logic                 rdDir, wrDir, addrEn, csSel;
  logic [2:0]           addrM1;
  logic [8:0]           followReg;
  logic [15:0]          addrLo;
  logic [HI_BITS-1:0]   addrHi;
  logic [LEN_W-1:0]     lenReg;
  logic [LEN_W-1:0]     idx;
  logic                 irqDone, irqXfer, irqErr;
  logic                 cmdReq, cfgWr, irqWr;
  logic [ADDR_BITS-1:0] addrVec, addrShift;

  assign cmdReq = regWe && (regIdx == 3'(REG_CMD)) && regWdata[CMD_GO];
  assign go     = cmdReq && !busy;
  assign cfgWr  = regWe && !busy;
  assign irqWr  = regWe && (regIdx == 3'(REG_IRQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode <= '0; rdDir <= 1'b0; wrDir <= 1'b0; addrEn <= 1'b0;
      addrM1 <= '0; csSel <= 1'b0;
    end else if (go) begin
      opcode <= regWdata[7:0];
      rdDir  <= regWdata[CMD_RD];
      wrDir  <= regWdata[CMD_WR] && !regWdata[CMD_RD];
      addrEn <= regWdata[CMD_ADR_EN];
      addrM1 <= regWdata[29:27];
      csSel  <= regWdata[CMD_CS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      followReg <= '0; addrLo <= '0; addrHi <= '0; lenReg <= '0;
    end else if (cfgWr) begin
      case (regIdx)
        3'(REG_FOLLOW):  followReg <= regWdata[8:0];
        3'(REG_ADDR_LO): addrLo    <= regWdata[15:0];
        3'(REG_ADDR_HI): addrHi    <= regWdata[HI_BITS-1:0];
        3'(REG_LEN):     lenReg    <= regWdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (ctl.idxClr) idx <= '0;
    else if (ctl.idxAdv) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqDone <= 1'b0; irqXfer <= 1'b0; irqErr <= 1'b0;
    end else begin
      irqDone <= ctl.setDone | (irqDone & ~(irqWr & regWdata[IRQ_DONE]));
      irqXfer <= ctl.setXfer | (irqXfer & ~(irqWr & regWdata[IRQ_XFER]));
      irqErr  <= (cmdReq & busy) | (irqErr & ~(irqWr & regWdata[IRQ_ERR]));
    end
  end

  always_comb begin
    irqStatus           = '0;
    irqStatus[IRQ_DONE] = irqDone;
    irqStatus[IRQ_XFER] = irqXfer;
    irqStatus[IRQ_ERR]  = irqErr;
  end

  assign addrVec   = {addrHi, addrLo};
  assign addrShift = addrVec >> {idx[2:0], 3'b000};

  always_comb begin
    unique case (ctl.ioSel)
      IO_OPC1: ioOut = opcode;
      IO_ADDR: ioOut = addrShift[7:0];
      IO_OPC2: ioOut = followReg[7:0];
      default: ioOut = bufRdData;
    endcase
  end

  assign ceN[0] = !(ctl.ceOn && !csSel);
  assign ceN[1] = !(ctl.ceOn && csSel);

  assign info.rd       = rdDir;
  assign info.addrEn   = addrEn;
  assign info.addrM1   = addrM1;
  assign info.followEn = followReg[FOLLOW_VAL];
  assign info.hasData  = (rdDir || wrDir) && (lenReg != '0);
  assign info.lastAddr = (idx[2:0] == addrM1);
  assign info.lastByte = (idx == lenReg - 1'b1);

  assign bufWrEn   = ctl.capture;
  assign bufWrIdx  = idx;
  assign bufWrData = ioIn;
  assign bufRdIdx  = idx;

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int STROBE_CYC = 2,
  parameter int TWB_CYC    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     go,
  input  logic     rb,
  input  seqInfo_t info,
  output logic     busy,
  output seqCtl_t  ctl,
  output logic     cle,
  output logic     ale,
  output logic     weN,
  output logic     reN,
  output logic     ioOe
);
  localparam int PH_N = 2 * STROBE_CYC;
  localparam int PH_W = $clog2(PH_N);
  localparam int WB_W = $clog2(TWB_CYC + 1);

  seqState_e       state, stateNext, afterAddr;
  logic            early, earlyNext, afterAddrEarly;
  logic [PH_W-1:0] phCnt;
  logic [WB_W-1:0] wbCnt;
  logic            busState, lowPhase, cycEnd, readData;

  assign busState = (state == ST_OPC1) || (state == ST_ADDR) ||
                    (state == ST_OPC2) || (state == ST_DATA);
  assign lowPhase = busState && (phCnt < PH_W'(STROBE_CYC));
  assign cycEnd   = busState && (phCnt == PH_W'(PH_N - 1));
  assign readData = (state == ST_DATA) && info.rd;

  always_comb begin
    if (info.followEn && info.rd) begin
      afterAddr = ST_OPC2; afterAddrEarly = 1'b1;
    end else if (info.hasData) begin
      afterAddr = ST_DATA; afterAddrEarly = 1'b0;
    end else if (info.followEn) begin
      afterAddr = ST_OPC2; afterAddrEarly = 1'b0;
    end else begin
      afterAddr = ST_FIN;  afterAddrEarly = 1'b0;
    end
  end

  always_comb begin
    stateNext = state;
    earlyNext = early;
    unique case (state)
      ST_IDLE: if (go) begin stateNext = ST_OPC1; earlyNext = 1'b0; end
      ST_OPC1: if (cycEnd) begin
        if (info.addrEn) stateNext = ST_ADDR;
        else begin stateNext = afterAddr; earlyNext = afterAddrEarly; end
      end
      ST_ADDR: if (cycEnd && info.lastAddr) begin
        stateNext = afterAddr; earlyNext = afterAddrEarly;
      end
      ST_DATA: if (cycEnd && info.lastByte)
        stateNext = (info.followEn && !early) ? ST_OPC2 : ST_FIN;
      ST_OPC2: if (cycEnd) stateNext = ST_WB;
      ST_WB:   if (wbCnt == WB_W'(TWB_CYC - 1)) stateNext = ST_BUSY;
      ST_BUSY: if (rb) stateNext = (early && info.hasData) ? ST_DATA : ST_FIN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; early <= 1'b0; phCnt <= '0; wbCnt <= '0;
    end else begin
      state <= stateNext;
      early <= earlyNext;
      phCnt <= (busState && !cycEnd) ? phCnt + 1'b1 : '0;
      wbCnt <= (state == ST_WB) ? wbCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    ctl.ceOn    = (state != ST_IDLE);
    unique case (state)
      ST_ADDR: ctl.ioSel = IO_ADDR;
      ST_OPC2: ctl.ioSel = IO_OPC2;
      ST_DATA: ctl.ioSel = IO_DATA;
      default: ctl.ioSel = IO_OPC1;
    endcase
    ctl.capture = readData && (phCnt == PH_W'(STROBE_CYC - 1));
    ctl.idxAdv  = cycEnd && (((state == ST_ADDR) && !info.lastAddr) ||
                             ((state == ST_DATA) && !info.lastByte));
    ctl.idxClr  = cycEnd && (((state == ST_ADDR) && info.lastAddr) ||
                             ((state == ST_DATA) && info.lastByte));
    ctl.setXfer = cycEnd && (state == ST_DATA) && info.lastByte;
    ctl.setDone = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);
  assign cle  = (state == ST_OPC1) || (state == ST_OPC2);
  assign ale  = (state == ST_ADDR);
  assign weN  = !(lowPhase && !readData);
  assign reN  = !(lowPhase && readData);
  assign ioOe = busState && !readData;

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int MAX_ADDR_CYC = 5,
  parameter int STROBE_CYC   = 2,
  parameter int TWB_CYC      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regIdx,
  input  logic [31:0]      regWdata,
  output logic [31:0]      irqStatus,
  output logic [1:0]       ceN,
  output logic             cle,
  output logic             ale,
  output logic             weN,
  output logic             reN,
  output logic [7:0]       ioOut,
  output logic             ioOe,
  input  logic [7:0]       ioIn,
  input  logic             rb,
  output logic             bufWrEn,
  output logic [LEN_W-1:0] bufWrIdx,
  output logic [7:0]       bufWrData,
  output logic [LEN_W-1:0] bufRdIdx,
  input  logic [7:0]       bufRdData
);
  seqCtl_t  ctl;
  seqInfo_t info;
  logic     go, busy;

  nand_seq_dp #(.LEN_W(LEN_W), .MAX_ADDR_CYC(MAX_ADDR_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .busy(busy), .ctl(ctl), .ioIn(ioIn), .bufRdData(bufRdData), .go(go),
    .info(info), .irqStatus(irqStatus), .ceN(ceN), .ioOut(ioOut),
    .bufWrEn(bufWrEn), .bufWrIdx(bufWrIdx), .bufWrData(bufWrData),
    .bufRdIdx(bufRdIdx)
  );

  nand_seq_ctrl #(.STROBE_CYC(STROBE_CYC), .TWB_CYC(TWB_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .rb(rb), .info(info), .busy(busy),
    .ctl(ctl), .cle(cle), .ale(ale), .weN(weN), .reN(reN), .ioOe(ioOe)
  );

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [2:0]  regIdx,
  input logic [31:0] regWdata,
  input logic [31:0] irqStatus,
  input logic [1:0]  ceN,
  input logic        cle,
  input logic        ale,
  input logic        weN,
  input logic        reN,
  input logic        ioOe
);
  logic irqClrDone, irqClrErr;
  assign irqClrDone = regWe && (regIdx == 3'd5) && regWdata[31];
  assign irqClrErr  = regWe && (regIdx == 3'd5) && regWdata[0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (ceN == 2'b11 && weN && reN && !cle && !ale && !ioOe && irqStatus == '0));

  assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  assert_one_ce_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~ceN) <= 1);

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !ioOe);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus[31] && !irqClrDone) |=> irqStatus[31]);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus[0] && !irqClrErr) |=> irqStatus[0]);

endmodule

bind nand_seq nand_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
  .irqStatus(irqStatus), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
  .reN(reN), .ioOe(ioOe)
);

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] irqStatus;
  logic [1:0]  ceN;
  logic        cle, ale, weN, reN, ioOe;
  logic [7:0]  ioOut;
  logic [7:0]  ioIn = '0;
  logic        rb = 1'b1;
  logic        bufWrEn;
  logic [11:0] bufWrIdx, bufRdIdx;
  logic [7:0]  bufWrData, bufRdData;

  logic [7:0] bufMem [16];
  logic [7:0] wbuf [16];
  int   logKind [64];
  int   logByte [64];
  logic [1:0] logCe [64];
  int   logN = 0, rdCount = 0, busyLeft = 0, viol = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  localparam int K_DATA = 0, K_CMD = 1, K_ADR = 2;

  always #2.5 clk = ~clk;

  nand_seq uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .irqStatus(irqStatus), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rb(rb), .bufWrEn(bufWrEn),
    .bufWrIdx(bufWrIdx), .bufWrData(bufWrData), .bufRdIdx(bufRdIdx),
    .bufRdData(bufRdData)
  );

  assign bufRdData = wbuf[bufRdIdx[3:0]];

  always @(posedge clk) if (bufWrEn) bufMem[bufWrIdx[3:0]] <= bufWrData;

  // Flash model: logs write-strobe rising edges, serves read bytes, models busy.
  always @(negedge clk) begin
    if (busyLeft > 0) begin
      busyLeft = busyLeft - 1;
      if (busyLeft == 0) rb = 1'b1;
    end
    if (!rb && (!weN || !reN)) viol = viol + 1;
    if (!prevWe && weN && logN < 64) begin
      logKind[logN] = cle ? K_CMD : (ale ? K_ADR : K_DATA);
      logByte[logN] = int'(ioOut);
      logCe[logN]   = ceN;
      logN = logN + 1;
      if (cle && (ioOut == 8'h30 || ioOut == 8'h10 || ioOut == 8'hD0)) begin
        rb = 1'b0;
        busyLeft = 6;
      end
    end
    if (!reN && prevRe) begin
      ioIn = 8'hA0 + 8'(rdCount);
      rdCount = rdCount + 1;
    end
    prevWe = weN;
    prevRe = reN;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic writeReg(input int idx, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1; regIdx = 3'(idx); regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!irqStatus[31] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done bit"}, int'(irqStatus[31]), 1);
  endtask

  task automatic newRun();
    writeReg(5, 32'h9000_0001);
    logN = 0; rdCount = 0; viol = 0;
  endtask

  task automatic expectLog(input string tag, input int i, input int kind, input int b);
    check({tag, " kind"}, logKind[i], kind);
    check({tag, " byte"}, logByte[i], b);
  endtask

  task automatic testReset();
    check("R1 ceN", int'(ceN), 3);
    check("R1 strobes", int'({weN, reN}), 3);
    check("R1 latches", int'({cle, ale, ioOe}), 0);
    check("R1 status", int'(irqStatus), 0);
  endtask

  task automatic testStatusRead();
    newRun();
    writeReg(4, 32'd1);
    writeReg(2, 32'h5A);
    writeReg(1, 32'h0);
    writeReg(0, 32'h8000_0000 | (32'h1 << 30) | (32'h1 << 26) | 32'h70);
    waitDone("R2 status read");
    check("R2 log count", logN, 2);
    expectLog("R2 opcode", 0, K_CMD, 'h70);
    check("R2 ce0 selected", int'(logCe[0]), 2);
    expectLog("R3 single address", 1, K_ADR, 'h5A);
    check("R6 read byte", int'(bufMem[0]), 'hA0);
    check("R8 xfer bit", int'(irqStatus[28]), 1);
    writeReg(5, 32'h9000_0000);
    check("R8 w1c clears", int'(irqStatus), 0);
  endtask

  task automatic testPageRead();
    newRun();
    writeReg(4, 32'd4);
    writeReg(2, 32'h0000_1234);
    writeReg(3, 32'h00AB_CDEF);
    writeReg(1, 32'h130);
    writeReg(0, 32'h8000_0000 | (32'h1 << 30) | (32'h4 << 27) | (32'h1 << 26) |
                (32'h1 << 19) | 32'h00);
    waitDone("R4 page read");
    check("R4 log count", logN, 7);
    expectLog("R2 read opcode", 0, K_CMD, 'h00);
    check("R2 ce1 selected", int'(logCe[0]), 1);
    expectLog("R3 addr0", 1, K_ADR, 'h34);
    expectLog("R3 addr1", 2, K_ADR, 'h12);
    expectLog("R3 addr2", 3, K_ADR, 'hEF);
    expectLog("R3 addr3", 4, K_ADR, 'hCD);
    expectLog("R3 addr4", 5, K_ADR, 'hAB);
    expectLog("R4 start after address", 6, K_CMD, 'h30);
    check("R5 no strobe while busy", viol, 0);
    for (int i = 0; i < 4; i++) check("R6 read buffer", int'(bufMem[i]), 'hA0 + i);
    check("R6 read strobe count", rdCount, 4);
  endtask

  task automatic testProgram();
    newRun();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    writeReg(4, 32'd3);
    writeReg(2, 32'h0000_0000);
    writeReg(3, 32'h0000_0042);
    writeReg(1, 32'h110);
    writeReg(0, 32'h8000_0000 | (32'h1 << 30) | (32'h3 << 27) | (32'h1 << 25) | 32'h80);
    waitDone("R7 program");
    check("R7 log count", logN, 9);
    expectLog("R7 opcode", 0, K_CMD, 'h80);
    expectLog("R3 addr0", 1, K_ADR, 'h00);
    expectLog("R3 addr2", 3, K_ADR, 'h42);
    expectLog("R3 addr3", 4, K_ADR, 'h00);
    expectLog("R7 data0", 5, K_DATA, 'h11);
    expectLog("R7 data1", 6, K_DATA, 'h22);
    expectLog("R7 data2", 7, K_DATA, 'h33);
    expectLog("R4 confirm after data", 8, K_CMD, 'h10);
    check("R5 program busy respected", viol, 0);
    check("R8 xfer after write", int'(irqStatus[28]), 1);
  endtask

  task automatic testErase();
    newRun();
    writeReg(4, 32'd5);
    writeReg(2, 32'h0000_5678);
    writeReg(3, 32'h0000_0009);
    writeReg(1, 32'h1D0);
    writeReg(0, 32'h8000_0000 | (32'h1 << 30) | (32'h2 << 27) | 32'h60);
    waitDone("R11 erase");
    check("R11 log count", logN, 5);
    expectLog("R11 opcode", 0, K_CMD, 'h60);
    expectLog("R3 row0", 1, K_ADR, 'h78);
    expectLog("R3 row2", 3, K_ADR, 'h09);
    expectLog("R4 confirm no data", 4, K_CMD, 'hD0);
    check("R11 no xfer bit", int'(irqStatus[28]), 0);
  endtask

  task automatic testZeroLen();
    newRun();
    writeReg(4, 32'd0);
    writeReg(1, 32'h0);
    writeReg(0, 32'h8000_0000 | (32'h1 << 26) | 32'h90);
    waitDone("R11 zero length");
    check("R11 zero length log", logN, 1);
    check("R11 zero length reads", rdCount, 0);
    check("R11 zero length xfer", int'(irqStatus[28]), 0);
  endtask

  task automatic testBusyWrite();
    newRun();
    writeReg(4, 32'd0);
    writeReg(2, 32'h0000_5678);
    writeReg(3, 32'h0000_0009);
    writeReg(1, 32'h1D0);
    writeReg(0, 32'h8000_0000 | (32'h1 << 30) | (32'h2 << 27) | 32'h60);
    writeReg(0, 32'h8000_0000 | 32'hEE);
    writeReg(1, 32'h0);
    waitDone("R9 busy write");
    check("R9 only first command", logN, 5);
    expectLog("R9 first opcode", 0, K_CMD, 'h60);
    expectLog("R9 follow register frozen", 4, K_CMD, 'hD0);
    check("R9 error bit", int'(irqStatus[0]), 1);
    repeat (5) @(negedge clk);
    check("R9 error sticky", int'(irqStatus[0]), 1);
    writeReg(5, 32'h1);
    check("R9 error cleared", int'(irqStatus[0]), 0);
    check("R8 done untouched by other clear", int'(irqStatus[31]), 1);
  endtask

  task automatic testSetWins();
    writeReg(1, 32'h0);
    check("R8 done preset", int'(irqStatus[31]), 1);
    logN = 0;
    writeReg(0, 32'h8000_0000 | 32'hFF);
    repeat (4) @(negedge clk);
    regWe = 1'b1; regIdx = 3'd5; regWdata = 32'h8000_0000;
    @(negedge clk);
    regWe = 1'b0;
    check("R8 set wins over clear", int'(irqStatus[31]), 1);
    check("R2 bare opcode", logN, 1);
    writeReg(5, 32'h8000_0000);
    check("R8 clear afterwards", int'(irqStatus[31]), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin bufMem[i] = '0; wbuf[i] = '0; end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testStatusRead();
    testPageRead();
    testProgram();
    testErase();
    testZeroLen();
    testBusyWrite();
    testSetWins();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule